// File: doc/BRIEF.md
# Program Fetch Router

This block sits between a processor's program counter and its instruction storage. Each fetch request carries a byte address. The router decides whether the byte comes from a small on-chip program ROM or from an external program memory, then returns the byte together with a one-cycle valid pulse.

The decision rests on two things. The first is a strap input that is captured while reset is asserted. The second is whether the address falls inside the on-chip ROM window at the bottom of the address space. With the strap high, addresses inside the window are served on-chip and every other address goes off-chip. With the strap low, the on-chip ROM is never used.

External reads use a time-shared low byte port. The port first carries the low address bits, which are held by an address strobe. The port is then released so that the memory can drive the data byte back, framed by an active-low read enable. A dedicated port carries the upper address bits. The on-chip ROM is a synchronous-read array. Its contents are given by a fixed arithmetic rule, so both the bench and the software image can predict them.

Top module: `fetch_router`

## Requirements
- R1: While reset is high and after it is released, with no request: fetch_valid=0, fetch_busy=0, ext_ale=0, ext_rd_n=1, ext_ad_oe=0.
- R2: The strap value present at the last clock edge with reset high selects the mode. Later changes of the strap have no effect on routing until the next reset.
- R3: With the strap captured high, a request for an address below 2**ROM_AW is served on-chip. fetch_valid is 1 in the cycle after the accepting edge, fetch_busy stays 0, and ext_ale never rises.
- R4: With the strap captured high, a request for an address at or above 2**ROM_AW is served externally.
- R5: With the strap captured low, every address from 0 to 2**ADDR_W-1 is served externally.
- R6: An external fetch runs over four cycles after the accepting edge. In cycle 1, ext_ale=1, ext_ad_oe=1, ext_ad_o=address[7:0] and ext_ah_o=address[ADDR_W-1:8]. In cycle 2, ext_ale=0 and the address is still driven. In cycle 3, ext_ad_oe=0 and ext_rd_n=0. In cycle 4, ext_rd_n=1, fetch_valid=1, and fetch_data holds ext_ad_i as sampled at the edge where ext_rd_n rose.
- R7: fetch_busy is 1 in cycles 1 to 3 of an external fetch. A request made while busy is dropped: it starts no strobe and produces no valid.
- R8: The on-chip ROM byte at address a is (a*37 + (a>>8)*11 + 60) mod 256.
- R9: fetch_valid is a single-cycle pulse per accepted fetch. It is 0 on the cycle after a completed fetch when no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_access_strap | input | 1 | Mode strap, captured during reset (1 = use on-chip ROM window) |
| fetch_req | input | 1 | Fetch request, accepted when fetch_busy is 0 |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_valid | output | 1 | One-cycle pulse, fetch_data holds the fetched byte |
| fetch_data | output | 8 | Fetched byte |
| fetch_busy | output | 1 | External fetch in progress |
| ext_ad_o | output | 8 | Multiplexed port, outgoing low address |
| ext_ad_oe | output | 1 | Drive enable for ext_ad_o (0 = released) |
| ext_ad_i | input | 8 | Multiplexed port, incoming data |
| ext_ah_o | output | ADDR_W-8 | Upper address bits |
| ext_ale | output | 1 | Address strobe, address held on its falling edge |
| ext_rd_n | output | 1 | Active-low read enable, data taken on its rising edge |

## Verification
The bench builds the router with ADDR_W=12 and ROM_AW=8. This gives a 4096-byte space with a 256-byte on-chip window, so every address can be fetched under both strap settings in one run. The window edge at 0FFh/100h is crossed in the sweep, and every on-chip byte is compared against the arithmetic ROM rule. The external memory model latches the address on the strobe's falling edge and answers from its own formula, so wrong address bits or a mistimed capture show up as bad data.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_HOLD,
    SQ_READ
  } seq_state_t;

  // Fill rule for the on-chip program ROM image
  function automatic logic [BYTE_W-1:0] rom_fill(input int unsigned a);
    int unsigned v;
    v = a * 37 + (a >> 8) * 11 + 60;
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/fr_strap_latch.sv
module fr_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap,
  output logic strap_q
);
  // Tracks the strap only while reset is high, then freezes
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap;
  end
endmodule

// File: rtl/fr_rom.sv
module fr_rom #(
  parameter int AW = 12
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [fr_pkg::BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [fr_pkg::BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fr_pkg::rom_fill(i);
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fr_ext_seq.sv
module fr_ext_seq #(
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [fr_pkg::BYTE_W-1:0] ad_i,
  output logic [fr_pkg::BYTE_W-1:0] ad_o,
  output logic                      ad_oe,
  output logic [ADDR_W-9:0]         ah_o,
  output logic                      ale,
  output logic                      rd_n,
  output logic                      busy,
  output logic                      done,
  output logic [fr_pkg::BYTE_W-1:0] data
);
  import fr_pkg::*;

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      ad_o  <= '0;
      ad_oe <= 1'b0;
      ah_o  <= '0;
      ale   <= 1'b0;
      rd_n  <= 1'b1;
      done  <= 1'b0;
      data  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          ad_o  <= addr[BYTE_W-1:0];
          ah_o  <= addr[ADDR_W-1:BYTE_W];
          ad_oe <= 1'b1;
          ale   <= 1'b1;
          state <= SQ_ADDR;
        end
        SQ_ADDR: begin
          ale   <= 1'b0;
          state <= SQ_HOLD;
        end
        SQ_HOLD: begin
          ad_oe <= 1'b0;
          rd_n  <= 1'b0;
          state <= SQ_READ;
        end
        default: begin
          rd_n  <= 1'b1;
          data  <= ad_i;
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/fetch_router.sv
module fetch_router #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_access_strap,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [7:0]        fetch_data,
  output logic              fetch_busy,
  output logic [7:0]        ext_ad_o,
  output logic              ext_ad_oe,
  input  logic [7:0]        ext_ad_i,
  output logic [ADDR_W-9:0] ext_ah_o,
  output logic              ext_ale,
  output logic              ext_rd_n
);
  logic       strap_q;
  logic       addr_in_window;
  logic       accept, in_rom, int_go, ext_go;
  logic       int_valid_q, sel_int_q;
  logic       ext_done;
  logic [7:0] rom_q, ext_data;

  fr_strap_latch u_strap (
    .clk(clk), .rst(rst), .strap(ext_access_strap), .strap_q(strap_q)
  );

  generate
    if (ROM_AW < ADDR_W) begin : g_window
      assign addr_in_window = (fetch_addr[ADDR_W-1:ROM_AW] == '0);
    end else begin : g_full
      assign addr_in_window = 1'b1;
    end
  endgenerate

  assign accept = fetch_req & ~fetch_busy;
  assign in_rom = strap_q & addr_in_window;
  assign int_go = accept & in_rom;
  assign ext_go = accept & ~in_rom;

  fr_rom #(.AW(ROM_AW)) u_rom (
    .clk(clk), .rd_en(int_go), .rd_addr(fetch_addr[ROM_AW-1:0]), .rd_data(rom_q)
  );

  fr_ext_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(ext_go), .addr(fetch_addr),
    .ad_i(ext_ad_i), .ad_o(ext_ad_o), .ad_oe(ext_ad_oe), .ah_o(ext_ah_o),
    .ale(ext_ale), .rd_n(ext_rd_n), .busy(fetch_busy),
    .done(ext_done), .data(ext_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_valid_q <= 1'b0;
      sel_int_q   <= 1'b0;
    end else begin
      int_valid_q <= int_go;
      if (accept) sel_int_q <= in_rom;
    end
  end

  assign fetch_valid = int_valid_q | ext_done;
  assign fetch_data  = sel_int_q ? rom_q : ext_data;
endmodule

// File: rtl/fr_checker.sv
module fr_checker (
  input logic clk,
  input logic rst,
  input logic strap_q,
  input logic fetch_valid,
  input logic fetch_busy,
  input logic ext_ale,
  input logic ext_ad_oe,
  input logic ext_rd_n
);
  // R2: captured strap never moves outside reset
  p_strap_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q));

  // R6: port released whenever read enable is low
  p_port_released_r6: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_ad_oe);

  // R6: address still driven when the strobe falls
  p_addr_held_at_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ale) |-> (ext_ad_oe && ext_rd_n));

  // R6: read enable rising delivers the byte
  p_valid_on_rd_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_rd_n) |-> (fetch_valid && !fetch_busy));

  // R7: strobe only inside a busy window
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ext_ale |-> fetch_busy);

  // R7: no result reported while busy
  p_no_valid_busy_r7: assert property (@(posedge clk) disable iff (rst)
    fetch_busy |-> !fetch_valid);
endmodule

bind fetch_router fr_checker u_fr_checker (
  .clk(clk), .rst(rst), .strap_q(strap_q), .fetch_valid(fetch_valid),
  .fetch_busy(fetch_busy), .ext_ale(ext_ale), .ext_ad_oe(ext_ad_oe),
  .ext_rd_n(ext_rd_n)
);

// File: tb/fetch_router_bench.sv
module fetch_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int RAW = 8;
  localparam int HW  = AW - 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap_in = 1'b1;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_valid, fetch_busy;
  logic [7:0]    fetch_data, ext_ad_o, ext_ad_i;
  logic          ext_ad_oe, ext_ale, ext_rd_n;
  logic [HW-1:0] ext_ah_o;

  int checks = 0;
  int fails  = 0;
  int ale_rises = 0;
  logic [AW-1:0] lat_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_router #(.ADDR_W(AW), .ROM_AW(RAW)) u_fetch_router (
    .clk(clk), .rst(rst), .ext_access_strap(strap_in),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_busy(fetch_busy),
    .ext_ad_o(ext_ad_o), .ext_ad_oe(ext_ad_oe), .ext_ad_i(ext_ad_i),
    .ext_ah_o(ext_ah_o), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n)
  );

  function automatic logic [7:0] rom_pat(input int a);
    return 8'((a * 37 + (a >> 8) * 11 + 60) & 255);
  endfunction

  function automatic logic [7:0] ext_pat(input int a);
    return 8'(((a * 13 + 7) ^ (a >> 4)) & 255);
  endfunction

  // External memory model
  always @(negedge ext_ale) lat_addr = {ext_ah_o, ext_ad_o};
  always @(posedge ext_ale) ale_rises++;
  assign ext_ad_i = !ext_rd_n ? ext_pat(int'(lat_addr)) : 8'hEE;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_in = strap; fetch_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(fetch_valid), 0);
    chk("R1 busy in reset", int'(fetch_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", int'(fetch_valid), 0);
    chk("R1 busy", int'(fetch_busy), 0);
    chk("R1 ale", int'(ext_ale), 0);
    chk("R1 rd_n", int'(ext_rd_n), 1);
    chk("R1 ad_oe", int'(ext_ad_oe), 0);
  endtask

  // Starts and ends at a negedge
  task automatic fetch(input int a, input bit exp_int, input string tag);
    int r0;
    r0 = ale_rises;
    fetch_req = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_req = 1'b0;
    if (exp_int) begin
      chk({tag, " internal valid"}, int'(fetch_valid), 1);
      chk("R8 rom byte", int'(fetch_data), int'(rom_pat(a)));
      chk("R3 no strobe", ale_rises, r0);
      chk("R3 not busy", int'(fetch_busy), 0);
    end else begin
      chk({tag, " strobe"}, int'(ext_ale), 1);
      chk("R6 c1 oe", int'(ext_ad_oe), 1);
      chk("R6 c1 low addr", int'(ext_ad_o), a & 255);
      chk("R6 c1 high addr", int'(ext_ah_o), a >> 8);
      chk("R7 c1 busy", int'(fetch_busy), 1);
      @(negedge clk);
      chk("R6 c2 ale low", int'(ext_ale), 0);
      chk("R6 c2 oe", int'(ext_ad_oe), 1);
      chk("R7 c2 busy", int'(fetch_busy), 1);
      @(negedge clk);
      chk("R6 c3 released", int'(ext_ad_oe), 0);
      chk("R6 c3 rd_n", int'(ext_rd_n), 0);
      chk("R7 c3 busy", int'(fetch_busy), 1);
      @(negedge clk);
      chk("R6 c4 rd_n", int'(ext_rd_n), 1);
      chk("R6 c4 valid", int'(fetch_valid), 1);
      chk("R6 c4 data", int'(fetch_data), int'(ext_pat(a)));
      chk("R7 c4 busy", int'(fetch_busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    // Strap high: full sweep crossing the window edge
    do_reset(1'b1);
    strap_in = 1'b0;  // R2: change after reset must not matter
    fetch(12'h020, 1'b1, "R2");
    for (int a = 0; a < (1 << AW); a++)
      fetch(a, a < (1 << RAW), (a < (1 << RAW)) ? "R3" : "R4");
    fetch(12'h0FF, 1'b1, "R3 edge");
    fetch(12'h100, 1'b0, "R4 edge");
    @(negedge clk);
    chk("R9 valid single pulse", int'(fetch_valid), 0);

    // R7: request during busy is dropped
    r0 = ale_rises;
    fetch_req = 1'b1; fetch_addr = 12'h300;
    @(negedge clk);
    fetch_addr = 12'h010;
    repeat (2) begin
      @(negedge clk);
      chk("R7 no valid while busy", int'(fetch_valid), 0);
    end
    @(negedge clk);
    fetch_req = 1'b0;
    chk("R7 data of first request", int'(fetch_data), int'(ext_pat(12'h300)));
    @(negedge clk);
    chk("R7 dropped request no valid", int'(fetch_valid), 0);
    chk("R7 single strobe", ale_rises, r0 + 1);

    // Strap low: every address goes off-chip
    do_reset(1'b0);
    strap_in = 1'b1;
    fetch(12'h020, 1'b0, "R2");
    for (int a = 0; a < (1 << AW); a++) fetch(a, 1'b0, "R5");
    @(negedge clk);
    chk("R9 valid after last", int'(fetch_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule